// File: doc/BRIEF.md
# Link Detect Substate Controller

This block runs the Detect stage of a serial link training sequencer. It has two substates, Quiet and Active. In Quiet it waits for a timeout, or for an assigned lane to leave electrical idle. In Active it asks the PHY for one receiver detection and reads back the per-lane results. It then either hands the link on to Polling or goes back to Quiet.

Each lane has an electrical-idle flag. A lane-assignment mask gates these flags, so lanes that belong to another protocol always look idle. A 2-bit code in a small control register sets a minimum Quiet dwell. Idle exits that arrive before the dwell has elapsed are ignored. The dwell applies again on every re-entry to Quiet, so the line capacitance can discharge between detections and detections never run back to back. All durations are converted to cycle counts through a cycles-per-microsecond parameter.

Top module: `lnk_detect_ctl`

## Requirements
- R1: A synchronous active-low reset puts the block in Quiet with the timer at zero, the control register at 0, `rx_found` at 0, and `det_req` and `go_poll` low.
- R2: `reg_rdata` always shows the control register, whose dwell code is bits [2:1].
  - `reg_wr` loads the whole word.
  - `reg_fld_wr` loads only bits [2:1] from `reg_wdata[2:1]` and keeps every other bit.
  - When both strobes are high, the full write wins.
- R3: If no idle exit is accepted, Quiet lasts exactly 12000 µs worth of cycles. `det_req` is high in the cycle after the last Quiet cycle.
- R4: The dwell code maps to a minimum count: 0 gives none, 1 gives 100 µs, 2 gives 1000 µs and 3 gives 2000 µs.
  - An idle exit seen while the Quiet cycle count (0 in the first cycle) is below that minimum is ignored.
  - At or above the minimum, the block leaves Quiet at that edge.
- R5: A lane whose `lane_assign` bit is 0 counts as idle and never causes a Quiet exit. Its `det_rx` bit is ignored.
- R6: `det_req` is a one-cycle pulse in the first Active cycle. The block then waits for `det_done`. A `det_done` outside that wait has no effect.
- R7: A `det_done` with no receiver on any assigned lane returns the block to Quiet with the timer restarted, so the dwell is enforced again.
- R8: A `det_done` with a receiver on any assigned lane raises `go_poll` and holds it until reset. `rx_found` takes `det_rx & lane_assign` at each accepted `det_done`.
- Encodings: `lane_eidle` bit = 1 means the lane is idle. `det_rx` bit = 1 means a receiver is present.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| lane_assign | input | LANES | 1 = lane belongs to this link |
| lane_eidle | input | LANES | 1 = lane in electrical idle |
| det_req | output | 1 | One-cycle receiver-detect request to the PHY |
| det_done | input | 1 | PHY detection complete |
| det_rx | input | LANES | Per-lane receiver present, valid with det_done |
| rx_found | output | LANES | Masked per-lane detect result |
| go_poll | output | 1 | Receiver found; move to Polling |
| in_quiet | output | 1 | Block is in the Quiet substate |
| reg_wr | input | 1 | Full control-register write |
| reg_fld_wr | input | 1 | Dwell-field-only write |
| reg_wdata | input | DW | Write data |
| reg_rdata | output | DW | Control register contents |

## Verification
Every output comes from a register, so each result appears one rising edge after the inputs it depends on were sampled:
- a Quiet exit shows as `det_req` one edge later;
- a `det_done` changes `go_poll`, `in_quiet` and `rx_found` one edge later;
- a register write is visible in `reg_rdata` after the same edge.

The bench drives its inputs just after a falling edge. It updates its behavioural model at the rising edge, from the same inputs the design samples, and compares all outputs at the next falling edge, once per cycle. The PHY responder answers three cycles after it sees `det_req`, so the wait state is always held for several cycles.

// File: rtl/lnk_detect_ctl.sv
module lnk_detect_ctl #(
  parameter int LANES      = 4,
  parameter int DW         = 8,
  parameter int CYC_PER_US = 100,
  parameter int TO_US      = 12000,
  parameter int MIN1_US    = 100,
  parameter int MIN2_US    = 1000,
  parameter int MIN3_US    = 2000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LANES-1:0] lane_assign,
  input  logic [LANES-1:0] lane_eidle,
  output logic             det_req,
  input  logic             det_done,
  input  logic [LANES-1:0] det_rx,
  output logic [LANES-1:0] rx_found,
  output logic             go_poll,
  output logic             in_quiet,
  input  logic             reg_wr,
  input  logic             reg_fld_wr,
  input  logic [DW-1:0]    reg_wdata,
  output logic [DW-1:0]    reg_rdata
);
  localparam int TO_CYC = TO_US * CYC_PER_US;
  localparam int TW     = $clog2(TO_CYC + 1);
  localparam logic [1:0] S_QUIET = 2'd0, S_REQ = 2'd1, S_WAIT = 2'd2, S_POLL = 2'd3;

  logic [1:0]    st;
  logic [TW-1:0] tmr;
  logic [TW-1:0] min_cyc;
  logic [DW-1:0] ctl;
  logic          idle_exit, tmo, q_exit, rx_hit;

  always_comb begin
    case (ctl[2:1])
      2'd0:    min_cyc = '0;
      2'd1:    min_cyc = TW'(MIN1_US * CYC_PER_US);
      2'd2:    min_cyc = TW'(MIN2_US * CYC_PER_US);
      default: min_cyc = TW'(MIN3_US * CYC_PER_US);
    endcase
  end

  assign idle_exit = |(~lane_eidle & lane_assign);
  assign tmo       = (tmr == TW'(TO_CYC - 1));
  assign q_exit    = tmo || (idle_exit && (tmr >= min_cyc));
  assign rx_hit    = |(det_rx & lane_assign);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_QUIET;
      tmr      <= '0;
      ctl      <= '0;
      rx_found <= '0;
    end else begin
      if (reg_wr)
        ctl <= reg_wdata;
      else if (reg_fld_wr)
        ctl[2:1] <= reg_wdata[2:1];
      case (st)
        S_QUIET:
          if (q_exit) begin
            st  <= S_REQ;
            tmr <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        S_REQ: st <= S_WAIT;
        S_WAIT:
          if (det_done) begin
            rx_found <= det_rx & lane_assign;
            if (rx_hit) begin
              st <= S_POLL;
            end else begin
              st  <= S_QUIET;
              tmr <= '0;
            end
          end
        default: ;
      endcase
    end
  end

  assign det_req   = (st == S_REQ);
  assign go_poll   = (st == S_POLL);
  assign in_quiet  = (st == S_QUIET);
  assign reg_rdata = ctl;
endmodule

module lnk_detect_ctl_chk #(
  parameter int LANES  = 4,
  parameter int DW     = 8,
  parameter int TW     = 8,
  parameter int TO_CYC = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic [LANES-1:0] lane_assign,
  input logic [LANES-1:0] lane_eidle,
  input logic             det_done,
  input logic [LANES-1:0] det_rx,
  input logic             det_req,
  input logic             go_poll,
  input logic             reg_wr,
  input logic             reg_fld_wr,
  input logic [DW-1:0]    reg_rdata,
  input logic [1:0]       st,
  input logic [TW-1:0]    tmr,
  input logic [TW-1:0]    min_cyc
);
  localparam logic [DW-1:0] KEEP = ~(DW'(6));

  p_field_keep_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_fld_wr && !reg_wr) |=> ((reg_rdata & KEEP) == ($past(reg_rdata) & KEEP)));

  p_timeout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && tmr == TW'(TO_CYC - 1)) |=> det_req);

  p_dwell_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && tmr < min_cyc && tmr != TW'(TO_CYC - 1)) |=> (st == 2'd0));

  p_unassigned_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd0 && ((~lane_eidle & lane_assign) == '0) && tmr != TW'(TO_CYC - 1)) |=> (st == 2'd0));

  p_req_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    det_req |=> !det_req);

  p_fail_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'd2 && det_done && ((det_rx & lane_assign) == '0)) |=> (st == 2'd0 && tmr == '0));

  p_poll_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    go_poll |=> go_poll);
endmodule

bind lnk_detect_ctl lnk_detect_ctl_chk #(.LANES(LANES), .DW(DW), .TW(TW), .TO_CYC(TO_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .lane_assign(lane_assign), .lane_eidle(lane_eidle),
  .det_done(det_done), .det_rx(det_rx), .det_req(det_req), .go_poll(go_poll),
  .reg_wr(reg_wr), .reg_fld_wr(reg_fld_wr), .reg_rdata(reg_rdata),
  .st(st), .tmr(tmr), .min_cyc(min_cyc)
);

// File: tb/lnk_detect_ctl_tb.sv
module lnk_detect_ctl_tb;
  localparam int LANES = 4;
  localparam int DW    = 8;
  localparam int CPU   = 1;
  localparam int TO    = 12000 * CPU;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LANES-1:0] lane_assign = 4'b0011;
  logic [LANES-1:0] lane_eidle = 4'b1111;
  logic phy_done = 1'b0, spur_done = 1'b0;
  logic [LANES-1:0] phy_rx = '0, spur_rx = '0, phy_resp_rx = '0;
  logic reg_wr = 1'b0, reg_fld_wr = 1'b0;
  logic [DW-1:0] reg_wdata = '0;
  wire det_done = phy_done | spur_done;
  wire [LANES-1:0] det_rx = phy_rx | spur_rx;
  logic det_req, go_poll, in_quiet;
  logic [LANES-1:0] rx_found;
  logic [DW-1:0] reg_rdata;

  int vectors = 0, miscompares = 0;
  bit running = 0, finished = 0;
  string ph = "R1";

  int m_st = 0, m_cnt = 0;
  logic [DW-1:0] m_ctl = '0;
  logic [LANES-1:0] m_found = '0;

  always #5 clk = ~clk;

  lnk_detect_ctl #(.LANES(LANES), .DW(DW), .CYC_PER_US(CPU)) u_dut (
    .clk(clk), .rst_n(rst_n), .lane_assign(lane_assign), .lane_eidle(lane_eidle),
    .det_req(det_req), .det_done(det_done), .det_rx(det_rx), .rx_found(rx_found),
    .go_poll(go_poll), .in_quiet(in_quiet), .reg_wr(reg_wr), .reg_fld_wr(reg_fld_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  function automatic int min_of(input logic [1:0] c);
    case (c)
      2'd0: return 0;
      2'd1: return 100 * CPU;
      2'd2: return 1000 * CPU;
      default: return 2000 * CPU;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_st = 0; m_cnt = 0; m_ctl = '0; m_found = '0;
    end else begin
      case (m_st)
        0: if (m_cnt == TO - 1 || ((|(~lane_eidle & lane_assign)) && m_cnt >= min_of(m_ctl[2:1]))) begin
             m_st = 1; m_cnt = 0;
           end else m_cnt++;
        1: m_st = 2;
        2: if (det_done) begin
             m_found = det_rx & lane_assign;
             if (|m_found) m_st = 3;
             else begin m_st = 0; m_cnt = 0; end
           end
        default: ;
      endcase
      if (reg_wr) m_ctl = reg_wdata;
      else if (reg_fld_wr) m_ctl[2:1] = reg_wdata[2:1];
    end
  end

  task automatic cmp(input string tag, input logic [31:0] act, input logic [31:0] exp);
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s/%s at %0t: actual %0h expected %0h", ph, tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) if (running) begin
    vectors++;
    cmp("R3 in_quiet", 32'(in_quiet), 32'(m_st == 0));
    cmp("R6 det_req", 32'(det_req), 32'(m_st == 1));
    cmp("R8 go_poll", 32'(go_poll), 32'(m_st == 3));
    cmp("R8 rx_found", 32'(rx_found), 32'(m_found));
    cmp("R2 reg_rdata", 32'(reg_rdata), 32'(m_ctl));
  end

  always begin
    @(negedge clk);
    if (det_req === 1'b1) begin
      repeat (3) @(negedge clk);
      #1; phy_done = 1'b1; phy_rx = phy_resp_rx;
      @(negedge clk);
      #1; phy_done = 1'b0; phy_rx = '0;
    end
  end

  task automatic nxt(input int n = 1);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    ph = "R1";
    nxt(3);
    running = 1;
    nxt(2);
    rst_n = 1'b1;
    nxt(3);
    ph = "R2";
    reg_wr = 1; reg_wdata = 8'hA5; nxt();
    reg_wr = 0; nxt();
    reg_fld_wr = 1; reg_wdata = 8'h06; nxt();
    reg_fld_wr = 0; nxt();
    reg_fld_wr = 1; reg_wdata = 8'hF9; nxt();
    reg_fld_wr = 0; nxt();
    reg_wr = 1; reg_fld_wr = 1; reg_wdata = 8'h10; nxt();
    reg_fld_wr = 0; reg_wdata = 8'h00; nxt();
    reg_wr = 0; nxt();
    ph = "R3";
    phy_resp_rx = '0;
    nxt(12100);
    ph = "R6";
    spur_done = 1; spur_rx = 4'b0011; nxt();
    spur_done = 0; spur_rx = '0; nxt(5);
    ph = "R4";
    reg_fld_wr = 1; reg_wdata = 8'h02; nxt();
    reg_fld_wr = 0;
    lane_eidle = 4'b1110;
    nxt(600);
    reg_fld_wr = 1; reg_wdata = 8'h04; nxt();
    reg_fld_wr = 0;
    nxt(2500);
    reg_fld_wr = 1; reg_wdata = 8'h00; nxt();
    reg_fld_wr = 0;
    nxt(50);
    ph = "R5";
    lane_eidle = 4'b1111;
    reg_fld_wr = 1; reg_wdata = 8'h06; nxt();
    reg_fld_wr = 0;
    nxt(20);
    lane_eidle = 4'b0111;
    nxt(3000);
    phy_resp_rx = 4'b1100;
    lane_eidle = 4'b1101;
    nxt(2100);
    ph = "R7";
    nxt(2100);
    ph = "R8";
    phy_resp_rx = 4'b0110;
    nxt(2100);
    lane_eidle = 4'b0000;
    spur_done = 1; spur_rx = 4'b0001; nxt();
    spur_done = 0; spur_rx = '0;
    nxt(50);
    ph = "R1";
    rst_n = 1'b0;
    nxt(2);
    rst_n = 1'b1;
    lane_eidle = 4'b1111;
    nxt(5);
    summary();
  end
endmodule